// File: doc/BRIEF.md
# Sleep Power-Reduction Sequencer

This block decides when a memory array may sit in its low-power state and when it must be brought back to full operation. It watches single-cycle sleep-entry and sleep-exit indications from the system, a level access request from the read path, and a 2-bit power-reduction policy. From these it drives a low-power enable for the array and a stall for the read path. The stall holds off an access until the array is usable again.

The policy sets the wake trigger. With the on-access policy, the array stays powered down after the system wakes and only returns on the first access. With the on-exit policy, the array returns as soon as the system leaves sleep. The off policy never powers the array down, and the reserved code behaves the same way. A wake-up takes a fixed number of cycles, set by the parameter `WAKE_CYC`, during which the stall stays asserted. After that the pending access proceeds.

Top module: `sleep_pwr_seq`

## Requirements
- R1: After reset, `array_lp_o` and `acc_stall_o` are both 0.
- R2: With `policy_i` equal to 2'b00 or 2'b01, a `sleep_enter_i` pulse while the array is active sets `array_lp_o` to 1 from the following cycle.
- R3: With `policy_i` = 2'b00, a `sleep_exit_i` pulse with no access request leaves `array_lp_o` at 1. A later access request starts the wake-up.
- R4: With `policy_i` = 2'b01, a `sleep_exit_i` pulse while in low power clears `array_lp_o` in the next cycle and starts the wake-up, with no access needed.
- R5: An access request while `array_lp_o` is 1 raises `acc_stall_o` in the same cycle. `array_lp_o` falls in the next cycle.
- R6: The wake-up phase lasts exactly `WAKE_CYC` cycles with `acc_stall_o` = 1 and `array_lp_o` = 0. `acc_stall_o` then falls, even if the request is still held.
- R7: With `policy_i` = 2'b11, `sleep_enter_i` is ignored: `array_lp_o` stays 0, and access requests are never stalled.
- R8: The reserved policy value 2'b10 behaves exactly like 2'b11.
- R9: If `policy_i` changes to 2'b10 or 2'b11 while the array is in low power, the wake-up starts at the next clock edge.
- R10: With `policy_i` = 2'b01, an access request while still in low power also starts the wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_enter_i | input | 1 | One-cycle pulse: system enters sleep |
| sleep_exit_i | input | 1 | One-cycle pulse: system leaves sleep |
| acc_req_i | input | 1 | Read path wants the array (level, held until served) |
| policy_i | input | 2 | Power-reduction policy: 00 on-access wake, 01 on-exit wake, 10 reserved, 11 off |
| array_lp_o | output | 1 | Array low-power enable |
| acc_stall_o | output | 1 | Holds off the read path while the array is unavailable |

## Verification
The state register shows directly at the ports, so a wrong state is visible within a cycle or two. A missed transition into low power shows as `array_lp_o` staying 0 one cycle after a sleep entry. A premature wake shows as `array_lp_o` falling after an exit under the on-access policy. A bad wake counter changes the run of stalled cycles: an access released one cycle early or late breaks the exact `WAKE_CYC` stall window. The bench therefore counts every stalled cycle and checks both outputs at each edge around every transition.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    POL_ACCESS_WAKE = 2'd0,
    POL_EXIT_WAKE   = 2'd1,
    POL_RESERVED    = 2'd2,
    POL_OFF         = 2'd3
  } slp_policy_e;

  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_LP   = 2'd1,
    ST_WAKE = 2'd2
  } slp_state_e;

endpackage

// File: rtl/slp_policy_dec.sv
module slp_policy_dec
  import slp_pkg::*;
(
  input  logic [1:0] policy_i,
  output logic       lp_allowed_o,
  output logic       exit_wake_o
);

  slp_policy_e pol;

  always_comb begin
    pol          = slp_policy_e'(policy_i);
    lp_allowed_o = 1'b0;
    exit_wake_o  = 1'b0;
    case (pol)
      POL_ACCESS_WAKE: lp_allowed_o = 1'b1;
      POL_EXIT_WAKE: begin
        lp_allowed_o = 1'b1;
        exit_wake_o  = 1'b1;
      end
      default: begin
        // reserved code falls back to the off policy (R8)
        lp_allowed_o = 1'b0;
        exit_wake_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run_i || (cnt_q != '0);
    cnt_d  = run_i ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R6: the count never runs past the last wake cycle
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= LAST));

  // R6: every wake phase starts from a cleared count
  a_r6_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (cnt_q == '0));

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_enter_i,
  input  logic sleep_exit_i,
  input  logic acc_req_i,
  input  logic lp_allowed_i,
  input  logic exit_wake_i,
  input  logic wake_done_i,
  output logic waking_o,
  output logic array_lp_o,
  output logic acc_stall_o
);

  slp_state_e state_q, state_d;
  logic       wake_req;

  always_comb begin
    wake_req = acc_req_i || !lp_allowed_i || (exit_wake_i && sleep_exit_i);
    state_d  = state_q;
    case (state_q)
      ST_ON:   if (sleep_enter_i && lp_allowed_i) state_d = ST_LP;
      ST_LP:   if (wake_req)                      state_d = ST_WAKE;
      ST_WAKE: if (wake_done_i)                   state_d = ST_ON;
      default:                                    state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ON;
    else        state_q <= state_d;
  end

  assign waking_o    = (state_q == ST_WAKE);
  assign array_lp_o  = (state_q == ST_LP);
  assign acc_stall_o = (state_q == ST_WAKE) || ((state_q == ST_LP) && acc_req_i);

  // R2: low power is only entered right after an allowed sleep entry
  a_r2_lp_needs_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(array_lp_o) |-> $past(sleep_enter_i && lp_allowed_i));

  // R3: on-access policy keeps the array down across a bare sleep exit
  a_r3_exit_keeps_lp: assert property (@(posedge clk) disable iff (!rst_n)
    (array_lp_o && lp_allowed_i && !exit_wake_i && !acc_req_i && sleep_exit_i)
    |=> array_lp_o);

  // R4: on-exit policy starts the wake on sleep exit
  a_r4_exit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (array_lp_o && exit_wake_i && sleep_exit_i) |=> (!array_lp_o && acc_stall_o));

  // R5: an access in low power leaves low power at the next edge, still stalled
  a_r5_access_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (array_lp_o && acc_req_i) |=> (!array_lp_o && acc_stall_o));

  // R7: with power reduction off, an active array stays active
  a_r7_off_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!array_lp_o && !acc_stall_o && !lp_allowed_i) |=> !array_lp_o);

endmodule

// File: rtl/sleep_pwr_seq.sv
module sleep_pwr_seq #(
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_enter_i,
  input  logic       sleep_exit_i,
  input  logic       acc_req_i,
  input  logic [1:0] policy_i,
  output logic       array_lp_o,
  output logic       acc_stall_o
);

  logic lp_allowed;
  logic exit_wake;
  logic waking;
  logic wake_done;

  slp_policy_dec u_dec (
    .policy_i     (policy_i),
    .lp_allowed_o (lp_allowed),
    .exit_wake_o  (exit_wake)
  );

  slp_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (waking),
    .done_o (wake_done)
  );

  slp_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_enter_i (sleep_enter_i),
    .sleep_exit_i  (sleep_exit_i),
    .acc_req_i     (acc_req_i),
    .lp_allowed_i  (lp_allowed),
    .exit_wake_i   (exit_wake),
    .wake_done_i   (wake_done),
    .waking_o      (waking),
    .array_lp_o    (array_lp_o),
    .acc_stall_o   (acc_stall_o)
  );

  // R9: a policy that forbids low power pulls the array out at the next edge
  a_r9_policy_off_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (array_lp_o && !lp_allowed) |=> !array_lp_o);

endmodule

// File: tb/sleep_pwr_seq_tb.sv
module sleep_pwr_seq_tb;

  localparam int unsigned W = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_enter, sleep_exit, acc_req;
  logic [1:0] policy;
  logic       array_lp, acc_stall;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sleep_pwr_seq #(.WAKE_CYC(W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_enter_i (sleep_enter),
    .sleep_exit_i  (sleep_exit),
    .acc_req_i     (acc_req),
    .policy_i      (policy),
    .array_lp_o    (array_lp),
    .acc_stall_o   (acc_stall)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // enter sleep from active; result observed one edge later
  task automatic go_sleep(input string tag, input logic exp_lp);
    tick();
    sleep_enter = 1'b1;
    #1;
    chk({tag, " lp before edge"}, array_lp, 1'b0);
    tick();
    sleep_enter = 1'b0;
    #1;
    chk({tag, " lp after enter"}, array_lp, exp_lp);
  endtask

  // called in the first wake cycle; checks the whole stall window
  task automatic expect_wake(input string tag);
    for (int i = 0; i < W; i++) begin
      chk({tag, " stall in wake"}, acc_stall, 1'b1);
      chk({tag, " lp off in wake"}, array_lp, 1'b0);
      tick();
    end
    chk({tag, " stall released"}, acc_stall, 1'b0);
    chk({tag, " lp after wake"}, array_lp, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sleep_enter = 1'b0; sleep_exit = 1'b0; acc_req = 1'b0; policy = 2'b00;
    #5;
    chk("R1 lp in reset", array_lp, 1'b0);
    chk("R1 stall in reset", acc_stall, 1'b0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 lp after reset", array_lp, 1'b0);
    chk("R1 stall after reset", acc_stall, 1'b0);
  endtask

  task automatic t_on_access();
    policy = 2'b00;
    go_sleep("R2 pol0", 1'b1);
    tick();
    sleep_exit = 1'b1;
    tick();
    sleep_exit = 1'b0;
    #1;
    chk("R3 lp kept after exit", array_lp, 1'b1);
    chk("R3 no stall after exit", acc_stall, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    chk("R3 lp still kept", array_lp, 1'b1);
    acc_req = 1'b1;
    #1;
    chk("R5 stall same cycle", acc_stall, 1'b1);
    chk("R5 lp same cycle", array_lp, 1'b1);
    tick();
    expect_wake("R6 pol0 held req");
    acc_req = 1'b0;
    #1;
    chk("R6 idle after release", acc_stall, 1'b0);
  endtask

  task automatic t_on_exit();
    policy = 2'b01;
    go_sleep("R2 pol1", 1'b1);
    tick();
    sleep_exit = 1'b1;
    #1;
    chk("R4 lp before edge", array_lp, 1'b1);
    chk("R4 no stall before edge", acc_stall, 1'b0);
    tick();
    sleep_exit = 1'b0;
    #1;
    expect_wake("R4 R6 pol1 exit");
  endtask

  task automatic t_on_exit_access();
    policy = 2'b01;
    go_sleep("R10 pol1", 1'b1);
    tick();
    acc_req = 1'b1;
    #1;
    chk("R10 stall on access", acc_stall, 1'b1);
    tick();
    expect_wake("R10 wake");
    acc_req = 1'b0;
  endtask

  task automatic t_off(input logic [1:0] pol, input string tag);
    policy = pol;
    go_sleep(tag, 1'b0);
    chk({tag, " no stall"}, acc_stall, 1'b0);
    acc_req = 1'b1;
    #1;
    chk({tag, " access not stalled"}, acc_stall, 1'b0);
    tick();
    chk({tag, " lp stays off"}, array_lp, 1'b0);
    chk({tag, " still not stalled"}, acc_stall, 1'b0);
    acc_req = 1'b0;
  endtask

  task automatic t_policy_change(input logic [1:0] pol, input string tag);
    policy = 2'b00;
    go_sleep(tag, 1'b1);
    tick();
    policy = pol;
    #1;
    chk({tag, " lp before edge"}, array_lp, 1'b1);
    tick();
    expect_wake(tag);
  endtask

  initial begin
    t_reset();
    t_on_access();
    t_on_exit();
    t_on_exit_access();
    t_off(2'b11, "R7 off");
    t_off(2'b10, "R8 reserved");
    t_policy_change(2'b11, "R9 to off");
    t_policy_change(2'b10, "R9 to reserved");
    tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule